// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Collision Arbitration

This block is a clocked 1024-word by 8-bit memory with two independent access ports, called left and right. Each port has its own active-low chip enable, write enable and output enable, a 10-bit address, write data and registered read data. Either port can read or write any word at any time, and both ports can read the same word in the same cycle.

When both enabled ports point at the same word, the block decides which port owns that word. The port that was already holding the address wins. On a tie the left port wins. The losing port sees an active-low busy flag, and its writes to that word are dropped while it loses. While the loser keeps reading the contested word, its read data is frozen. It picks up new contents only after the flag releases, or after it changes its address or its write enable.

A static mode input turns the instance into a slave for width expansion. In that mode the block does no arbitration of its own. Its busy outputs stay inactive, and each port's active-low busy input stops that port's writes.

Top module: `dualport_arb_ram`

## Requirements
- R1: A write is taken when chip enable and write enable are both low at a clock edge. A read with chip enable low, write enable high and output enable low returns the addressed word on that port's read data after the next clock edge. Data written through one port is readable through the other, at any address from 0x000 to 0x3FF.
- R2: When both ports read the same word in the same cycle, both read data outputs carry that word.
- R3: Busy flags are registered. A busy output goes low only in the cycle after a clock edge at which both chip enables were low with equal addresses, in master mode. At most one busy output is low at a time.
- R4: The winner is decided when the collision starts. If a port had chip enable low on the same address at the previous edge and the other port did not, the first port wins. In every other case the left port wins. The loser's busy goes low, and the winner's busy stays high.
- R5: Both busy outputs return high after an edge at which either chip enable was high or the addresses differed.
- R6: A write from the losing port does not change memory. This holds both for the edge at which the collision is detected and for every later edge while it lasts.
- R7: With chip enable high, a low write enable changes no memory word.
- R8: With the slave mode input high, both busy outputs stay high. A write on a port whose busy input is low changes no memory, and with the busy input high the write proceeds as in R1.
- R9: While a port is flagged busy and its address and write enable are unchanged from the previous edge, its read data keeps its value even if the winner rewrites the word. The first read after the flag releases returns the current contents.
- R10: Read data is 0x00 after reset, and after any edge at which that port had chip enable high, output enable high, or a write in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| slaveMode | input | 1 | 1 selects slave mode: external busy inputs gate writes |
| leftCeN | input | 1 | Left chip enable, active low |
| leftWeN | input | 1 | Left write enable, active low |
| leftOeN | input | 1 | Left output enable, active low |
| leftAddr | input | 10 | Left word address |
| leftWrData | input | 8 | Left write data |
| leftRdData | output | 8 | Left registered read data |
| leftBusyN | output | 1 | Left busy flag (master mode), active low |
| leftBusyInN | input | 1 | Left busy input (slave mode), active low |
| rightCeN | input | 1 | Right chip enable, active low |
| rightWeN | input | 1 | Right write enable, active low |
| rightOeN | input | 1 | Right output enable, active low |
| rightAddr | input | 10 | Right word address |
| rightWrData | input | 8 | Right write data |
| rightRdData | output | 8 | Right registered read data |
| rightBusyN | output | 1 | Right busy flag (master mode), active low |
| rightBusyInN | input | 1 | Right busy input (slave mode), active low |

## Verification
The hardest state to reach is the frozen read of R9. The loser must already hold read data from the contested word, the winner must then rewrite that word, and the loser's inputs must not change at all. The stimulus parks the left port reading a word and then brings the right port onto it one cycle later, so the right port loses. The left port then switches to writing while the right inputs stay fixed. Releasing the left chip enable afterwards shows the stale value persisting for one more edge and the fresh value on the edge after.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrLeft;
    logic wrRight;
    logic rdLeft;
    logic rdRight;
    logic holdLeft;
    logic holdRight;
  } strobe_t;

endpackage

// File: rtl/dpr_port_track.sv
// Remembers what one port did at the previous edge so that the
// arbiter can tell an established access from a new arrival.
module dpr_port_track #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic              onSameAddr,
  output logic              inputsSteady
);

  logic              prevActive;
  logic [ADDR_W-1:0] prevAddr;
  logic              prevWeN;

  assign active       = !ceN;
  assign onSameAddr   = active && prevActive && (prevAddr == addr);
  assign inputsSteady = onSameAddr && (prevWeN == weN);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prevActive <= 1'b0;
      prevAddr   <= '0;
      prevWeN    <= 1'b1;
    end else begin
      prevActive <= active;
      prevAddr   <= addr;
      prevWeN    <= weN;
    end
  end

endmodule

// File: rtl/dpr_ctrl.sv
module dpr_ctrl
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slaveMode,
  input  logic              leftCeN,
  input  logic              leftWeN,
  input  logic              leftOeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftBusyInN,
  input  logic              rightCeN,
  input  logic              rightWeN,
  input  logic              rightOeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightBusyInN,
  output strobe_t           strb,
  output logic              leftBusyN,
  output logic              rightBusyN
);

  logic leftActive, leftSame, leftSteady;
  logic rightActive, rightSame, rightSteady;
  logic addrMatch;
  logic blockLeft, blockRight;
  owner_e ownerQ, nextOwner;

  dpr_port_track #(.ADDR_W(ADDR_W)) u_trackLeft (
    .clk(clk), .rst(rst), .ceN(leftCeN), .weN(leftWeN), .addr(leftAddr),
    .active(leftActive), .onSameAddr(leftSame), .inputsSteady(leftSteady)
  );

  dpr_port_track #(.ADDR_W(ADDR_W)) u_trackRight (
    .clk(clk), .rst(rst), .ceN(rightCeN), .weN(rightWeN), .addr(rightAddr),
    .active(rightActive), .onSameAddr(rightSame), .inputsSteady(rightSteady)
  );

  assign addrMatch = leftActive && rightActive && (leftAddr == rightAddr);

  // First-come decision; an ongoing collision keeps its owner.
  always_comb begin
    nextOwner = OWN_NONE;
    if (!slaveMode && addrMatch) begin
      if (ownerQ != OWN_NONE && leftSame && rightSame) begin
        nextOwner = ownerQ;
      end else if (rightSame && !leftSame) begin
        nextOwner = OWN_RIGHT;
      end else begin
        nextOwner = OWN_LEFT;
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) ownerQ <= OWN_NONE;
    else     ownerQ <= nextOwner;
  end

  // The write gate uses the decision of this edge, so a losing write
  // never lands, not even in the cycle the collision starts.
  assign blockLeft  = slaveMode ? !leftBusyInN  : (nextOwner == OWN_RIGHT);
  assign blockRight = slaveMode ? !rightBusyInN : (nextOwner == OWN_LEFT);

  always_comb begin
    strb.wrLeft    = leftActive  && !leftWeN  && !blockLeft;
    strb.wrRight   = rightActive && !rightWeN && !blockRight;
    strb.rdLeft    = leftActive  &&  leftWeN  && !leftOeN;
    strb.rdRight   = rightActive &&  rightWeN && !rightOeN;
    strb.holdLeft  = (ownerQ == OWN_RIGHT) && leftSteady;
    strb.holdRight = (ownerQ == OWN_LEFT)  && rightSteady;
  end

  assign leftBusyN  = (ownerQ != OWN_RIGHT);
  assign rightBusyN = (ownerQ != OWN_LEFT);

endmodule

// File: rtl/dpr_datapath.sv
module dpr_datapath
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftWrData,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightWrData,
  output logic [DATA_W-1:0] leftRdData,
  output logic [DATA_W-1:0] rightRdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Left is written last, so it wins an unarbitrated same-word write.
  always_ff @(posedge clk) begin
    if (strb.wrRight) mem[rightAddr] <= rightWrData;
    if (strb.wrLeft)  mem[leftAddr]  <= leftWrData;
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [ADDR_W-1:0] addr;
    logic              rdEn;
    logic              hold;
    logic [DATA_W-1:0] q;

    assign addr = (p == 0) ? leftAddr : rightAddr;
    assign rdEn = (p == 0) ? strb.rdLeft : strb.rdRight;
    assign hold = (p == 0) ? strb.holdLeft : strb.holdRight;

    always_ff @(posedge clk or posedge rst) begin
      if (rst)        q <= '0;
      else if (!rdEn) q <= '0;
      else if (!hold) q <= mem[addr];
    end
  end

  assign leftRdData  = g_rd[0].q;
  assign rightRdData = g_rd[1].q;

endmodule

// File: rtl/dualport_arb_ram.sv
module dualport_arb_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slaveMode,
  input  logic              leftCeN,
  input  logic              leftWeN,
  input  logic              leftOeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftWrData,
  output logic [DATA_W-1:0] leftRdData,
  output logic              leftBusyN,
  input  logic              leftBusyInN,
  input  logic              rightCeN,
  input  logic              rightWeN,
  input  logic              rightOeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightWrData,
  output logic [DATA_W-1:0] rightRdData,
  output logic              rightBusyN,
  input  logic              rightBusyInN
);

  strobe_t strb;

  dpr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .slaveMode(slaveMode),
    .leftCeN(leftCeN), .leftWeN(leftWeN), .leftOeN(leftOeN),
    .leftAddr(leftAddr), .leftBusyInN(leftBusyInN),
    .rightCeN(rightCeN), .rightWeN(rightWeN), .rightOeN(rightOeN),
    .rightAddr(rightAddr), .rightBusyInN(rightBusyInN),
    .strb(strb), .leftBusyN(leftBusyN), .rightBusyN(rightBusyN)
  );

  dpr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .leftAddr(leftAddr), .leftWrData(leftWrData),
    .rightAddr(rightAddr), .rightWrData(rightWrData),
    .leftRdData(leftRdData), .rightRdData(rightRdData)
  );

endmodule

// File: rtl/dualport_arb_ram_chk.sv
module dualport_arb_ram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              slaveMode,
  input logic              leftCeN,
  input logic              leftWeN,
  input logic              leftOeN,
  input logic [ADDR_W-1:0] leftAddr,
  input logic [DATA_W-1:0] leftRdData,
  input logic              leftBusyN,
  input logic              rightCeN,
  input logic              rightOeN,
  input logic [ADDR_W-1:0] rightAddr,
  input logic [DATA_W-1:0] rightRdData,
  input logic              rightBusyN
);

  AST_BUSY_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    !(!leftBusyN && !rightBusyN)); // R3

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!leftBusyN || !rightBusyN) |->
      $past(!leftCeN && !rightCeN && (leftAddr == rightAddr) && !slaveMode)); // R3

  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $past(leftCeN || rightCeN || (leftAddr != rightAddr)) |-> (leftBusyN && rightBusyN)); // R5

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(slaveMode) |-> (leftBusyN && rightBusyN)); // R8

  AST_LEFT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(leftCeN || leftOeN || !leftWeN) |-> (leftRdData == '0)); // R10

  AST_RIGHT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rightCeN || rightOeN) |-> (rightRdData == '0)); // R10

endmodule

bind dualport_arb_ram dualport_arb_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .slaveMode(slaveMode),
  .leftCeN(leftCeN), .leftWeN(leftWeN), .leftOeN(leftOeN), .leftAddr(leftAddr),
  .leftRdData(leftRdData), .leftBusyN(leftBusyN),
  .rightCeN(rightCeN), .rightOeN(rightOeN), .rightAddr(rightAddr),
  .rightRdData(rightRdData), .rightBusyN(rightBusyN)
);

// File: tb/dualport_arb_ram_tb_top.sv
`timescale 1ns/1ps
module dualport_arb_ram_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slaveMode = 1'b0;
  logic       leftCeN = 1'b1, leftWeN = 1'b1, leftOeN = 1'b1;
  logic [9:0] leftAddr = '0;
  logic [7:0] leftWrData = '0;
  logic [7:0] leftRdData;
  logic       leftBusyN, leftBusyInN = 1'b1;
  logic       rightCeN = 1'b1, rightWeN = 1'b1, rightOeN = 1'b1;
  logic [9:0] rightAddr = '0;
  logic [7:0] rightWrData = '0;
  logic [7:0] rightRdData;
  logic       rightBusyN, rightBusyInN = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dualport_arb_ram dut_i (
    .clk(clk), .rst(rst), .slaveMode(slaveMode),
    .leftCeN(leftCeN), .leftWeN(leftWeN), .leftOeN(leftOeN),
    .leftAddr(leftAddr), .leftWrData(leftWrData), .leftRdData(leftRdData),
    .leftBusyN(leftBusyN), .leftBusyInN(leftBusyInN),
    .rightCeN(rightCeN), .rightWeN(rightWeN), .rightOeN(rightOeN),
    .rightAddr(rightAddr), .rightWrData(rightWrData), .rightRdData(rightRdData),
    .rightBusyN(rightBusyN), .rightBusyInN(rightBusyInN)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic driveL(logic ce, logic we, logic oe, logic [9:0] a, logic [7:0] d);
    leftCeN = ce; leftWeN = we; leftOeN = oe; leftAddr = a; leftWrData = d;
  endtask

  task automatic driveR(logic ce, logic we, logic oe, logic [9:0] a, logic [7:0] d);
    rightCeN = ce; rightWeN = we; rightOeN = oe; rightAddr = a; rightWrData = d;
  endtask

  task automatic idleBoth();
    driveL(1, 1, 1, '0, '0);
    driveR(1, 1, 1, '0, '0);
  endtask

  task automatic writeL(logic [9:0] a, logic [7:0] d);
    driveL(0, 0, 0, a, d); tick(); driveL(1, 1, 1, '0, '0);
  endtask

  task automatic writeR(logic [9:0] a, logic [7:0] d);
    driveR(0, 0, 0, a, d); tick(); driveR(1, 1, 1, '0, '0);
  endtask

  task automatic readL(string req, logic [9:0] a, logic [7:0] exp);
    driveL(0, 1, 0, a, '0); tick();
    chk(req, "left read", leftRdData, exp);
    driveL(1, 1, 1, '0, '0);
  endtask

  task automatic readR(string req, logic [9:0] a, logic [7:0] exp);
    driveR(0, 1, 0, a, '0); tick();
    chk(req, "right read", rightRdData, exp);
    driveR(1, 1, 1, '0, '0);
  endtask

  task automatic testReset();
    chk("R10", "left data at reset", leftRdData, 8'h00);
    chk("R10", "right data at reset", rightRdData, 8'h00);
    chk("R3", "left busy at reset", {7'd0, leftBusyN}, 8'h01);
    chk("R3", "right busy at reset", {7'd0, rightBusyN}, 8'h01);
  endtask

  task automatic testBasicRw();
    driveL(0, 0, 0, 10'h005, 8'h3C); tick();
    chk("R10", "left data during write", leftRdData, 8'h00);
    driveL(1, 1, 1, '0, '0);
    writeR(10'h3FF, 8'hC3);
    writeL(10'h000, 8'h81);
    readR("R1", 10'h005, 8'h3C);
    readL("R1", 10'h3FF, 8'hC3);
    readR("R1", 10'h000, 8'h81);
  endtask

  task automatic testNoCeWrite();
    driveL(1, 0, 0, 10'h005, 8'hFF); tick();
    driveL(1, 1, 1, '0, '0);
    readL("R7", 10'h005, 8'h3C);
  endtask

  task automatic testDualRead();
    driveL(0, 1, 0, 10'h005, '0);
    driveR(0, 1, 0, 10'h005, '0);
    tick();
    chk("R2", "left shared read", leftRdData, 8'h3C);
    chk("R2", "right shared read", rightRdData, 8'h3C);
    chk("R4", "tie: right flagged", {7'd0, rightBusyN}, 8'h00);
    chk("R4", "tie: left free", {7'd0, leftBusyN}, 8'h01);
    idleBoth(); tick();
  endtask

  task automatic testRightFirst();
    driveR(0, 1, 0, 10'h010, '0); tick();
    chk("R3", "no busy without match", {6'd0, leftBusyN, rightBusyN}, 8'h03);
    driveL(0, 1, 0, 10'h010, '0); tick();
    chk("R4", "right first: left flagged", {7'd0, leftBusyN}, 8'h00);
    chk("R4", "right first: right free", {7'd0, rightBusyN}, 8'h01);
    driveR(0, 1, 0, 10'h011, '0); tick();
    chk("R5", "release on mismatch", {6'd0, leftBusyN, rightBusyN}, 8'h03);
    idleBoth(); tick();
  endtask

  task automatic testTieWrite();
    driveL(0, 0, 0, 10'h020, 8'h5A);
    driveR(0, 0, 0, 10'h020, 8'hA5);
    tick();
    chk("R4", "tie write: right flagged", {7'd0, rightBusyN}, 8'h00);
    idleBoth(); tick();
    readL("R6", 10'h020, 8'h5A);
  endtask

  task automatic testBlockedWrite();
    writeL(10'h030, 8'h44);
    driveL(0, 1, 0, 10'h030, '0); tick();
    driveR(0, 0, 0, 10'h030, 8'h99); tick();
    chk("R4", "left first: right flagged", {7'd0, rightBusyN}, 8'h00);
    tick();
    chk("R3", "busy held", {7'd0, rightBusyN}, 8'h00);
    idleBoth(); tick();
    readR("R6", 10'h030, 8'h44);
  endtask

  task automatic testFrozenRead();
    writeL(10'h040, 8'h11);
    driveL(0, 1, 0, 10'h040, '0); tick();
    driveR(0, 1, 0, 10'h040, '0); tick();
    chk("R9", "loser first read", rightRdData, 8'h11);
    driveL(0, 0, 0, 10'h040, 8'h22); tick();
    chk("R9", "frozen after winner write", rightRdData, 8'h11);
    chk("R9", "loser still flagged", {7'd0, rightBusyN}, 8'h00);
    driveL(0, 1, 0, 10'h040, '0); tick();
    chk("R9", "still frozen", rightRdData, 8'h11);
    driveL(1, 1, 1, '0, '0); tick();
    chk("R5", "release on ce high", {7'd0, rightBusyN}, 8'h01);
    chk("R9", "frozen on release edge", rightRdData, 8'h11);
    tick();
    chk("R9", "fresh data after release", rightRdData, 8'h22);
    idleBoth(); tick();
  endtask

  task automatic testOutputOff();
    driveL(0, 1, 1, 10'h005, '0); tick();
    chk("R10", "oe high", leftRdData, 8'h00);
    driveL(0, 1, 0, 10'h005, '0); tick();
    chk("R1", "oe low", leftRdData, 8'h3C);
    driveL(1, 1, 0, 10'h005, '0); tick();
    chk("R10", "ce high", leftRdData, 8'h00);
    idleBoth(); tick();
  endtask

  task automatic testSlave();
    writeL(10'h050, 8'h12);
    slaveMode = 1'b1; tick();
    driveL(0, 1, 0, 10'h050, '0);
    driveR(0, 1, 0, 10'h050, '0);
    tick(); tick();
    chk("R8", "slave busy outputs high", {6'd0, leftBusyN, rightBusyN}, 8'h03);
    chk("R8", "slave shared read", rightRdData, 8'h12);
    idleBoth();
    leftBusyInN = 1'b0; writeL(10'h050, 8'h66); leftBusyInN = 1'b1;
    readR("R8", 10'h050, 8'h12);
    rightBusyInN = 1'b0; writeR(10'h050, 8'h67); rightBusyInN = 1'b1;
    readL("R8", 10'h050, 8'h12);
    writeL(10'h050, 8'h77);
    readR("R8", 10'h050, 8'h77);
    slaveMode = 1'b0; tick();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    testReset();
    testBasicRw();
    testNoCeWrite();
    testDualRead();
    testRightFirst();
    testTieWrite();
    testBlockedWrite();
    testFrozenRead();
    testOutputOff();
    testSlave();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule